// File: doc/BRIEF.md
# Interlocked Linked Queue Engine

This engine inserts entries into, and removes entries from, a circular doubly linked queue kept in shared memory. Each node, the queue header included, is two words wide. The word at offset 0 is the forward link and the word at offset 4 is the backward link. Links are absolute byte addresses. An empty queue is a header whose two links both hold the header's own address. A command names the header, the operation and, for inserts, the entry. The engine works at the head (the header's forward side) or the tail (the header's backward side).

The engine first requests the shared-memory interlock and holds it until the response. It then reads the links it needs. Before any write, it checks every node address it will touch against an external permission input and against node alignment. After all checks pass, it rewrites the links of up to three nodes. Because the interlock is held for the whole operation, several processors can share one queue without any other synchronization.

Top module: `lq_engine`

## Requirements
- R1: Out of reset, `cmd_ready_o` is 1 and `lock_req_o`, `mem_req_o` and `resp_valid_o` are 0. A command is taken only in a cycle where `cmd_valid_i` and `cmd_ready_o` are both 1.
- R2: `cmd_op_i` bit 1 selects remove (1) or insert (0), and bit 0 selects tail (1) or head (0). `resp_status_o` reads 0 for done, 1 for empty and 2 for fault. `resp_valid_o` is a one-cycle pulse per command.
- R3: An insert at the head into an empty queue makes both header links point to the entry and both entry links point to the header. It returns `resp_flag_o`=1, meaning the queue was empty before.
- R4: An insert at the head into a non-empty queue works as follows. The entry's forward link becomes the old first node and its backward link becomes the header. The old first node's backward link and the header's forward link become the entry. The flag is 0.
- R5: An insert at the tail mirrors R4. The entry's backward link becomes the old last node and its forward link becomes the header. The old last node's forward link and the header's backward link become the entry.
- R6: A remove at the head returns the first node on `resp_entry_o` and unlinks it between the header and the second node. The remove leaves the removed node's own links unchanged. `resp_flag_o` is 1 when the queue is empty afterwards.
- R7: A remove at the tail returns the last node and unlinks it in the same way as R6, mirrored.
- R8: A remove from an empty queue returns status empty and writes no memory.
- R9: If `chk_ok_i` is 0 for any node address the operation will touch, the operation returns status fault and writes no memory.
- R10: A header, entry or link whose low three address bits are not zero gives status fault and writes no memory.
- R11: Memory is accessed only while `lock_req_o` and `lock_gnt_i` are both 1. `lock_req_o` stays high from the command until the response pulse, when it drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Engine idle, command accepted |
| cmd_op_i | input | 2 | bit1 remove, bit0 tail |
| cmd_hdr_i | input | AW | Queue header address |
| cmd_entry_i | input | AW | Entry address for inserts |
| lock_req_o | output | 1 | Interlock request, held for the operation |
| lock_gnt_i | input | 1 | Interlock granted |
| chk_addr_o | output | AW | Node address under permission check |
| chk_ok_i | input | 1 | Access to `chk_addr_o` permitted (same cycle) |
| mem_req_o | output | 1 | Memory access |
| mem_we_o | output | 1 | Write when 1, read when 0 |
| mem_addr_o | output | AW | Byte address of link word |
| mem_wdata_o | output | AW | Write data |
| mem_rdata_i | input | AW | Read data, one cycle after read request |
| resp_valid_o | output | 1 | Result pulse |
| resp_status_o | output | 2 | 0 done, 1 empty, 2 fault |
| resp_entry_o | output | AW | Removed node address |
| resp_flag_o | output | 1 | Insert: was empty; remove: now empty |

## Verification
The bench builds the engine with AW=32, so links are 4 bytes, nodes are 8 bytes and alignment covers three address bits. A small word memory holds one header and three entries. This lets a single run grow the queue from both ends and drain it from both ends back to empty. It also exercises a permission refusal on the second node of a remove, plus misaligned entry and header addresses. The interlock grant lags the request by a cycle, which brings the wait for the lock within reach.

// File: rtl/lq_pkg.sv
package lq_pkg;
  typedef enum logic [1:0] {
    ST_DONE  = 2'd0,
    ST_EMPTY = 2'd1,
    ST_FAULT = 2'd2
  } lq_status_e;

  typedef enum logic [3:0] {
    S_IDLE, S_LOCK, S_CHK_H, S_RD1, S_CAP1, S_CHK1,
    S_RD2, S_CAP2, S_CHK2, S_WR, S_RESP
  } lq_state_e;
endpackage

// File: rtl/lq_addr_check.sv
module lq_addr_check #(
  parameter int unsigned AW      = 32,
  parameter int unsigned ALIGN_W = 3
) (
  input  logic [AW-1:0] addr_i,
  input  logic          perm_i,
  output logic          ok_o
);
  assign ok_o = perm_i && (addr_i[ALIGN_W-1:0] == '0);
endmodule

// File: rtl/lq_link_step.sv
module lq_link_step #(
  parameter int unsigned AW     = 32,
  parameter int unsigned LINK_B = 4
) (
  input  logic [1:0]    step_i,
  input  logic          remove_i,
  input  logic          tail_i,
  input  logic [AW-1:0] hdr_i,
  input  logic [AW-1:0] entry_i,
  input  logic [AW-1:0] l1_i,
  input  logic [AW-1:0] l2_i,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] data_o
);
  logic [AW-1:0] near, far;
  assign near = tail_i ? AW'(LINK_B) : '0;  // link on the side being worked
  assign far  = tail_i ? '0 : AW'(LINK_B);

  always_comb begin
    addr_o = '0;
    data_o = '0;
    if (remove_i) begin
      if (step_i[0] == 1'b0) begin addr_o = hdr_i + near; data_o = l2_i; end
      else                   begin addr_o = l2_i + far;   data_o = hdr_i; end
    end else begin
      unique case (step_i)
        2'd0: begin addr_o = entry_i + near; data_o = l1_i;    end
        2'd1: begin addr_o = entry_i + far;  data_o = hdr_i;   end
        2'd2: begin addr_o = l1_i + far;     data_o = entry_i; end
        default: begin addr_o = hdr_i + near; data_o = entry_i; end
      endcase
    end
  end
endmodule

// File: rtl/lq_engine.sv
module lq_engine
  import lq_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  output logic          cmd_ready_o,
  input  logic [1:0]    cmd_op_i,
  input  logic [AW-1:0] cmd_hdr_i,
  input  logic [AW-1:0] cmd_entry_i,
  output logic          lock_req_o,
  input  logic          lock_gnt_i,
  output logic [AW-1:0] chk_addr_o,
  input  logic          chk_ok_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [AW-1:0] mem_wdata_o,
  input  logic [AW-1:0] mem_rdata_i,
  output logic          resp_valid_o,
  output logic [1:0]    resp_status_o,
  output logic [AW-1:0] resp_entry_o,
  output logic          resp_flag_o
);
  localparam int unsigned LINK_B  = AW / 8;
  localparam int unsigned NODE_B  = 2 * LINK_B;
  localparam int unsigned ALIGN_W = $clog2(NODE_B);

  lq_state_e     state_q;
  logic          remove_q, tail_q;
  logic [AW-1:0] hdr_q, entry_q, l1_q, l2_q;
  logic [1:0]    step_q;
  lq_status_e    status_q;
  logic [AW-1:0] res_entry_q;
  logic          flag_q;

  logic          addr_ok;
  logic [AW-1:0] wr_addr, wr_data, near;
  logic          last_step;

  assign near      = tail_q ? AW'(LINK_B) : '0;
  assign last_step = remove_q ? (step_q == 2'd1) : (step_q == 2'd3);

  always_comb begin
    unique case (state_q)
      S_CHK1:  chk_addr_o = l1_q;
      S_CHK2:  chk_addr_o = remove_q ? l2_q : entry_q;
      default: chk_addr_o = hdr_q;
    endcase
  end

  lq_addr_check #(.AW(AW), .ALIGN_W(ALIGN_W)) i_chk (
    .addr_i (chk_addr_o),
    .perm_i (chk_ok_i),
    .ok_o   (addr_ok)
  );

  lq_link_step #(.AW(AW), .LINK_B(LINK_B)) i_step (
    .step_i   (step_q),
    .remove_i (remove_q),
    .tail_i   (tail_q),
    .hdr_i    (hdr_q),
    .entry_i  (entry_q),
    .l1_i     (l1_q),
    .l2_i     (l2_q),
    .addr_o   (wr_addr),
    .data_o   (wr_data)
  );

  assign cmd_ready_o   = (state_q == S_IDLE);
  assign lock_req_o    = !(state_q inside {S_IDLE, S_RESP});
  assign mem_req_o     = state_q inside {S_RD1, S_RD2, S_WR};
  assign mem_we_o      = (state_q == S_WR);
  assign mem_addr_o    = (state_q == S_WR)  ? wr_addr :
                         (state_q == S_RD2) ? l1_q + near : hdr_q + near;
  assign mem_wdata_o   = (state_q == S_WR) ? wr_data : '0;
  assign resp_valid_o  = (state_q == S_RESP);
  assign resp_status_o = status_q;
  assign resp_entry_o  = res_entry_q;
  assign resp_flag_o   = flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      remove_q    <= 1'b0;
      tail_q      <= 1'b0;
      hdr_q       <= '0;
      entry_q     <= '0;
      l1_q        <= '0;
      l2_q        <= '0;
      step_q      <= '0;
      status_q    <= ST_DONE;
      res_entry_q <= '0;
      flag_q      <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (cmd_valid_i) begin
          remove_q <= cmd_op_i[1];
          tail_q   <= cmd_op_i[0];
          hdr_q    <= cmd_hdr_i;
          entry_q  <= cmd_entry_i;
          state_q  <= S_LOCK;
        end
        S_LOCK: if (lock_gnt_i) state_q <= S_CHK_H;
        S_CHK_H: if (addr_ok) state_q <= S_RD1;
                 else begin status_q <= ST_FAULT; res_entry_q <= '0; flag_q <= 1'b0; state_q <= S_RESP; end
        S_RD1:  state_q <= S_CAP1;
        S_CAP1: begin
          l1_q <= mem_rdata_i;
          if (remove_q && mem_rdata_i == hdr_q) begin
            status_q <= ST_EMPTY; res_entry_q <= '0; flag_q <= 1'b1; state_q <= S_RESP;
          end else state_q <= S_CHK1;
        end
        S_CHK1: if (!addr_ok) begin
                  status_q <= ST_FAULT; res_entry_q <= '0; flag_q <= 1'b0; state_q <= S_RESP;
                end else state_q <= remove_q ? S_RD2 : S_CHK2;
        S_RD2:  state_q <= S_CAP2;
        S_CAP2: begin l2_q <= mem_rdata_i; state_q <= S_CHK2; end
        S_CHK2: if (!addr_ok) begin
                  status_q <= ST_FAULT; res_entry_q <= '0; flag_q <= 1'b0; state_q <= S_RESP;
                end else begin step_q <= '0; state_q <= S_WR; end
        S_WR: begin
          step_q <= step_q + 2'd1;
          if (last_step) begin
            status_q    <= ST_DONE;
            res_entry_q <= remove_q ? l1_q : '0;
            flag_q      <= remove_q ? (l2_q == hdr_q) : (l1_q == hdr_q);
            state_q     <= S_RESP;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // assertions
  logic wr_seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          wr_seen_q <= 1'b0;
    else if (cmd_ready_o) wr_seen_q <= 1'b0;
    else if (mem_we_o)    wr_seen_q <= 1'b1;
  end

  p_mem_locked_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (lock_req_o && lock_gnt_i));
  p_lock_release_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_req_o) |-> resp_valid_o);
  p_resp_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |=> !resp_valid_o);
  p_no_write_fault_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && resp_status_o != 2'd0) |-> !wr_seen_q);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> (!lock_req_o && !mem_req_o));
endmodule

// File: tb/test_lq_engine.sv
module test_lq_engine;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [1:0]    cmd_op = '0;
  logic [AW-1:0] cmd_hdr = '0, cmd_entry = '0;
  logic          lock_req, lock_gnt = 1'b0;
  logic [AW-1:0] chk_addr;
  logic          chk_ok;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic          resp_valid, resp_flag;
  logic [1:0]    resp_status;
  logic [AW-1:0] resp_entry;

  logic [AW-1:0] mem [32];
  logic [AW-1:0] deny = 32'hFFFF_FFFF;
  int            nwr = 0, viol = 0, checks = 0, fails = 0;
  logic [1:0]    r_status;
  logic [AW-1:0] r_entry;
  logic          r_flag;
  int            r_wr;

  always #4 clk = ~clk;  // 125 MHz

  assign chk_ok = (chk_addr != deny);

  lq_engine #(.AW(AW)) i_lq_engine (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_op_i(cmd_op),
    .cmd_hdr_i(cmd_hdr), .cmd_entry_i(cmd_entry),
    .lock_req_o(lock_req), .lock_gnt_i(lock_gnt),
    .chk_addr_o(chk_addr), .chk_ok_i(chk_ok),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .resp_valid_o(resp_valid), .resp_status_o(resp_status),
    .resp_entry_o(resp_entry), .resp_flag_o(resp_flag)
  );

  always @(posedge clk) begin
    lock_gnt <= lock_req;
    if (mem_req) begin
      if (!(lock_req && lock_gnt)) viol <= viol + 1;
      if (mem_we) begin mem[mem_addr[6:2]] <= mem_wdata; nwr <= nwr + 1; end
      else mem_rdata <= mem[mem_addr[6:2]];
    end
  end

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] op, input logic [AW-1:0] hdr, input logic [AW-1:0] ent);
    int w0;
    @(negedge clk);
    w0 = nwr;
    cmd_op = op; cmd_hdr = hdr; cmd_entry = ent; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int i = 0; i < 100 && !resp_valid; i++) @(negedge clk);
    chk("R2 response", {31'b0, resp_valid}, 1);
    r_status = resp_status; r_entry = resp_entry; r_flag = resp_flag;
    @(negedge clk);
    chk("R2 pulse", {31'b0, resp_valid}, 0);
    chk("R11 lock released", {31'b0, lock_req}, 0);
    r_wr = nwr - w0;
  endtask

  task automatic t_reset;
    chk("R1 ready", {31'b0, cmd_ready}, 1);
    chk("R1 no lock", {31'b0, lock_req}, 0);
    chk("R1 no mem", {31'b0, mem_req}, 0);
    chk("R1 no resp", {31'b0, resp_valid}, 0);
  endtask

  task automatic t_ins_head_empty;
    run_op(2'b00, 32'h00, 32'h10);
    chk("R3 status", r_status, 0); chk("R3 flag", r_flag, 1);
    chk("R3 h.f", mem[0], 32'h10); chk("R3 h.b", mem[1], 32'h10);
    chk("R3 e.f", mem[4], 32'h00); chk("R3 e.b", mem[5], 32'h00);
  endtask

  task automatic t_ins_head;
    run_op(2'b00, 32'h00, 32'h18);
    chk("R4 status", r_status, 0); chk("R4 flag", r_flag, 0);
    chk("R4 h.f", mem[0], 32'h18); chk("R4 h.b", mem[1], 32'h10);
    chk("R4 e.f", mem[6], 32'h10); chk("R4 e.b", mem[7], 32'h00);
    chk("R4 old.b", mem[5], 32'h18);
  endtask

  task automatic t_ins_tail;
    run_op(2'b01, 32'h00, 32'h20);
    chk("R5 status", r_status, 0); chk("R5 flag", r_flag, 0);
    chk("R5 h.b", mem[1], 32'h20); chk("R5 e.f", mem[8], 32'h00);
    chk("R5 e.b", mem[9], 32'h10); chk("R5 old.f", mem[4], 32'h20);
    chk("R5 h.f", mem[0], 32'h18);
  endtask

  task automatic t_misaligned_entry;
    run_op(2'b01, 32'h00, 32'h24);
    chk("R10 status", r_status, 2); chk("R10 writes", r_wr, 0);
    chk("R10 h.b", mem[1], 32'h20);
  endtask

  task automatic t_denied;
    deny = 32'h10;
    run_op(2'b10, 32'h00, 32'h0);
    deny = 32'hFFFF_FFFF;
    chk("R9 status", r_status, 2); chk("R9 writes", r_wr, 0);
    chk("R9 h.f", mem[0], 32'h18);
  endtask

  task automatic t_rem_head;
    run_op(2'b10, 32'h00, 32'h0);
    chk("R6 status", r_status, 0); chk("R6 entry", r_entry, 32'h18);
    chk("R6 flag", r_flag, 0); chk("R6 h.f", mem[0], 32'h10);
    chk("R6 next.b", mem[5], 32'h00); chk("R6 node kept", mem[6], 32'h10);
  endtask

  task automatic t_rem_tail;
    run_op(2'b11, 32'h00, 32'h0);
    chk("R7 status", r_status, 0); chk("R7 entry", r_entry, 32'h20);
    chk("R7 flag", r_flag, 0); chk("R7 h.b", mem[1], 32'h10);
    chk("R7 prev.f", mem[4], 32'h00);
  endtask

  task automatic t_rem_last;
    run_op(2'b10, 32'h00, 32'h0);
    chk("R6 last entry", r_entry, 32'h10); chk("R6 now empty", r_flag, 1);
    chk("R6 h.f", mem[0], 32'h00); chk("R6 h.b", mem[1], 32'h00);
  endtask

  task automatic t_rem_empty;
    run_op(2'b11, 32'h00, 32'h0);
    chk("R8 status", r_status, 1); chk("R8 writes", r_wr, 0);
    chk("R8 h.b", mem[1], 32'h00);
  endtask

  task automatic t_misaligned_hdr;
    run_op(2'b10, 32'h04, 32'h0);
    chk("R10 hdr status", r_status, 2); chk("R10 hdr writes", r_wr, 0);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ins_head_empty();
    t_ins_head();
    t_ins_tail();
    t_misaligned_entry();
    t_denied();
    t_rem_head();
    t_rem_tail();
    t_rem_last();
    t_rem_empty();
    t_misaligned_hdr();
    chk("R11 accesses under lock", viol, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule